// File: doc/BRIEF.md
# Phase-Frequency Detector with Antibacklash Overlap

This block compares two divided edge streams in one fast clock domain. One stream comes from the reference divider and the other from the feedback divider. A rising edge on the reference stream sets the up output. A rising edge on the feedback stream sets the down output. The difference in the width of the two pulses shows the phase and frequency error. Downstream logic turns that difference into charge-pump current.

Once both outputs are set, neither is cleared at once. A counter holds both high for `ANTIBACKLASH_CYCLES` fast-clock periods, and then both are cleared in the same cycle. As a result, every comparison produces a short, equal-width overlap on both outputs, even at zero phase error. This overlap removes the dead zone around zero error and keeps the reference spur level steady.

A rising edge that arrives while both outputs are set is held and applied right after the clear. A one-cycle strobe marks each completed comparison for a lock detector. The divider inputs are plain levels sampled on the fast clock. They carry no data payload, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `pfd_antibacklash`

## Requirements
- R1: If `ref_div_i` is sampled low at one rising clock edge and high at the next (edge k), then `up_o` is high after edge k+1, unless both outputs are already high at that point.
- R2: If `fb_div_i` is sampled low and then high at edge k, then `down_o` is high after edge k+1 under the same condition.
- R3: While only one output is high, it stays high. Further rising edges on its own input have no effect on its pulse width.
- R4: Once both outputs are high, both stay high for exactly `ANTIBACKLASH_CYCLES` clock cycles (default 3, minimum 2 for the hold-over timing of R5), then both go low in the same cycle. This holds at zero phase error too. The pulse widths are therefore (later edge − earlier edge + `ANTIBACKLASH_CYCLES`) for the leading output and `ANTIBACKLASH_CYCLES` for the lagging one.
- R5: A rising edge that is detected while both outputs are high, including in the clearing cycle, is held. It sets its output one cycle after the clear.
- R6: `pfd_cycle_o` is high for exactly one cycle, which is the first cycle after the clear. In that cycle both outputs are low. It is raised once per comparison.
- R7: While `rst_n` is low at a rising clock edge, both outputs, the strobe, the delay counter and the held edges are cleared.
- R8: An input held high produces only one rising edge. A level that stays high never sets its output again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_div_i | input | 1 | Divided reference stream, drives the up output |
| fb_div_i | input | 1 | Divided feedback stream, drives the down output |
| up_o | output | 1 | Up pulse level |
| down_o | output | 1 | Down pulse level |
| pfd_cycle_o | output | 1 | One-cycle strobe after each clear |

## Verification
Some rules are checked on every cycle by the assertions:
- an output set by a fresh edge;
- a lone output that never drops;
- a joint clear that leaves both outputs low;
- a held edge applied once the overlap ends;
- a strobe that is a single cycle long.

The exact overlap length of `ANTIBACKLASH_CYCLES` and the resulting pulse widths for leading, lagging and coincident edges are measured only by the bench's scenarios. The same holds for the placement of a held edge relative to the strobe, the blindness to long high levels, and the reset that lands mid-pulse.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned NUM_CH = 2;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pfd_edge_detect.sv
module pfd_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic div_i,
  output logic edge_o
);
  logic samp_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= div_i;
      prev_q <= samp_q;
    end
  end

  assign edge_o = samp_q & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) edge_o |=> !edge_o); // R8
endmodule

// File: rtl/pfd_set_flop.sv
module pfd_set_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic busy_i,
  input  logic clr_i,
  output logic q_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_o    <= 1'b0;
      pend_q <= 1'b0;
    end else if (busy_i) begin
      if (clr_i) q_o <= 1'b0;
      pend_q <= pend_q | edge_i;
    end else if (edge_i || pend_q) begin
      q_o    <= 1'b1;
      pend_q <= 1'b0;
    end
  end

  AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (edge_i && !busy_i) |=> q_o); // R1
  AST_PEND_APPLY:  assert property (@(posedge clk) disable iff (!rst_n) (pend_q && !busy_i) |=> q_o); // R5
endmodule

// File: rtl/pfd_clear_delay.sv
module pfd_clear_delay #(
  parameter int unsigned DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic clr_o,
  output logic cycle_o
);
  localparam int unsigned CW = pfd_pkg::cnt_width(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;

  assign clr_o = busy_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cycle_o <= 1'b0;
    end else begin
      cycle_o <= clr_o;
      if (busy_i && !clr_o) cnt_q <= cnt_q + 1'b1;
      else                  cnt_q <= '0;
    end
  end

  AST_CLEAR_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) clr_o |=> !busy_i); // R4
  AST_STROBE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) cycle_o |=> !cycle_o); // R6
  AST_STROBE_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) cycle_o |-> !busy_i); // R6
endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash #(
  parameter int unsigned ANTIBACKLASH_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_div_i,
  input  logic fb_div_i,
  output logic up_o,
  output logic down_o,
  output logic pfd_cycle_o
);
  import pfd_pkg::*;

  logic [NUM_CH-1:0] div_vec, edge_vec, flag_vec;
  logic both_set, clear_now;

  assign div_vec  = {fb_div_i, ref_div_i};
  assign both_set = &flag_vec;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      pfd_edge_detect i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .div_i (div_vec[g]),
        .edge_o(edge_vec[g])
      );
      pfd_set_flop i_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .edge_i(edge_vec[g]),
        .busy_i(both_set),
        .clr_i (clear_now),
        .q_o   (flag_vec[g])
      );
    end
  endgenerate

  pfd_clear_delay #(.DELAY(ANTIBACKLASH_CYCLES)) i_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (both_set),
    .clr_o  (clear_now),
    .cycle_o(pfd_cycle_o)
  );

  assign up_o   = flag_vec[0];
  assign down_o = flag_vec[1];

  AST_JOINT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clear_now |=> (!up_o && !down_o)); // R4
  AST_UP_HOLDS:    assert property (@(posedge clk) disable iff (!rst_n) (up_o && !down_o) |=> up_o); // R3
  AST_DOWN_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n) (down_o && !up_o) |=> down_o); // R3
endmodule

// File: tb/test_pfd_antibacklash.sv
`timescale 1ns/1ps
module test_pfd_antibacklash;
  localparam int AB = 3;

  typedef struct {
    int    up_len;
    int    dn_len;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, ref_div = 1'b0, fb_div = 1'b0;
  logic up, dn, strobe;
  int   errors = 0, checks = 0, cyc = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];
  int   upc = 0, dnc = 0, last_up = 0, last_dn = 0;

  always #4 clk = ~clk;

  pfd_antibacklash #(.ANTIBACKLASH_CYCLES(AB)) i_pfd_antibacklash (
    .clk(clk), .rst_n(rst_n), .ref_div_i(ref_div), .fb_div_i(fb_div),
    .up_o(up), .down_o(dn), .pfd_cycle_o(strobe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int u, input int d, input string tag);
    exp_t e;
    e.up_len = u; e.dn_len = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_div = 1'b0; fb_div = 1'b0;
    end
  endtask

  // Monitor: measures pulse runs, pops an expected item on each strobe.
  always @(negedge clk) begin
    if (!rst_n) begin
      upc = 0; dnc = 0;
    end else begin
      if (up) upc++; else if (upc > 0) begin last_up = upc; upc = 0; end
      if (dn) dnc++; else if (dnc > 0) begin last_dn = dnc; dnc = 0; end
      if (strobe) begin
        if (exp_q.size() == 0) begin
          chk("R6 unexpected strobe", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({e.tag, " up width"}, last_up, e.up_len);
          chk({e.tag, " down width"}, last_dn, e.dn_len);
          chk("R6 both low at strobe", int'(up | dn), 0);
        end
      end
    end
  end

  // Driver: rising edges at index a and b, held for hold cycles.
  task automatic run_pair(input int a, input int b, input int hold, input string tag);
    int mx;
    mx = (a > b) ? a : b;
    push(mx - a + AB, mx - b + AB, tag);
    for (int t = 0; t < mx + hold; t++) begin
      @(negedge clk);
      ref_div = (t >= a) && (t < a + hold);
      fb_div  = (t >= b) && (t < b + hold);
    end
    idle(20);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      chk("watchdog expired", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(4);
    chk("R7 up in reset", int'(up), 0);
    chk("R7 down in reset", int'(dn), 0);
    chk("R7 strobe in reset", int'(strobe), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(5);

    run_pair(0, 5, 2, "R1 ref leads");
    run_pair(7, 0, 3, "R2 fb leads");
    run_pair(0, 0, 3, "R4 zero error");
    run_pair(4, 4, 1, "R4 zero error short");

    // R3: second ref edge while up already set
    push(10 + AB, AB, "R3 extra ref edge");
    for (int t = 0; t < 14; t++) begin
      @(negedge clk);
      ref_div = (t < 2) || (t == 4) || (t == 5);
      fb_div  = (t == 10) || (t == 11);
    end
    idle(20);

    // R5: ref re-rises in the clearing cycle
    push(AB, AB, "R4 hold-over first");
    push(11, AB, "R5 hold-over second");
    for (int t = 0; t < 12 + AB + 6; t++) begin
      @(negedge clk);
      if (t == AB + 2) begin
        chk("R6 strobe after clear", int'(strobe), 1);
        chk("R5 up low in strobe cycle", int'(up), 0);
      end
      if (t == AB + 3) chk("R5 held edge applied", int'(up), 1);
      ref_div = (t == 0) || (t == AB);
      fb_div  = (t == 0) || (t == 12);
    end
    idle(20);

    // R8: long high level on ref
    push(3 + AB, AB, "R8 long level");
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (t == 30) chk("R8 level does not re-set up", int'(up), 0);
      ref_div = 1'b1;
      fb_div  = (t == 3) || (t == 4);
    end
    idle(20);

    // R7: reset in the middle of a lone up pulse
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      if (t == 4) chk("R1 up set before reset", int'(up), 1);
      ref_div = (t == 0);
      fb_div  = 1'b0;
    end
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R7 up cleared by reset", int'(up), 0);
    chk("R7 strobe cleared by reset", int'(strobe), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(5);
    chk("R7 no output after reset", int'(up | dn), 0);
    run_pair(2, 6, 2, "R2 after reset");

    chk("R4 all comparisons completed", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule